// File: doc/BRIEF.md
# Boot Overlay Memory Bank Decoder

This block decodes the 64K memory space of an 8-bit processor into chip-selects for two boot ROM regions, a small overlay static RAM and up to four 16K system RAM banks. After reset a boot overlay covers the lowest 8K. Reads in that window go to the ROMs or to the overlay RAM. Writes aimed at ROM addresses drop through to the system RAM hidden underneath, which lets loader code fill low RAM before the overlay is switched off.

Two control bits live in I/O ports that the processor writes. One bit in the mapping port removes the overlay, which leaves plain RAM from address 0. One bit in the protect port allows writes to the overlay RAM. Reset clears both bits, so the overlay starts enabled and its RAM starts write-protected. The address decode is combinational. The control bits are registered.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After reset the overlay is enabled and the overlay RAM is write-protected. A read of 0000h selects the first ROM, and a write to 1400h selects nothing.
- R2: An I/O write of a byte with bit 5 = 1 to port F2h removes the overlay, and every address then decodes to system RAM. Writing bit 5 = 0 restores the overlay.
- R3: While the overlay is enabled, reads of 0000h-1FFFh never select system RAM. 0000h-0FFFh selects ROM 0. 1000h-13FFh and 1800h-1FFFh select ROM 1.
- R4: While the overlay is enabled, a write to a ROM address in 0000h-1FFFh selects system RAM bank 0 and asserts the write-enable qualifier.
- R5: While the overlay is enabled, 1400h-17FFh selects the overlay RAM for reads, taking priority over ROM 1.
- R6: A write to 1400h-17FFh selects the overlay RAM only when bit 7 of port 7Fh is 1. Otherwise the write selects nothing. Such a write never selects system RAM while the overlay is enabled.
- R7: System RAM bank k (k = address bits 15:14) is selected only when k is less than the installed bank count `banks_i`. Above the installed top nothing is selected.
- R8: A port write changes only the control register at its own port address. Writes to other ports, and all bits other than bit 5 of F2h and bit 7 of 7Fh, have no effect on decoding.
- R9: At most one chip-select is active at a time. No select is active without a read or write strobe. `wr_en_o` is high only for a write that produces a select. When both strobes are high, the write takes precedence.
- R10: A control port write takes effect in the decode from the clock edge that captures it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Memory address |
| rd_i | input | 1 | Memory read strobe |
| wr_i | input | 1 | Memory write strobe |
| io_wr_i | input | 1 | I/O port write cycle |
| io_addr_i | input | 8 | I/O port address |
| io_data_i | input | 8 | I/O write data |
| banks_i | input | 3 | Installed 16K system RAM banks (1..4) |
| rom0_cs_o | output | 1 | Boot/monitor ROM select |
| rom1_cs_o | output | 1 | Second ROM region select |
| oram_cs_o | output | 1 | Overlay RAM select |
| sram_cs_o | output | 4 | System RAM bank selects |
| wr_en_o | output | 1 | Write permitted to the selected device |

## Verification
Decode is tried at both edges of every overlay sub-range. Reads and writes are compared there, which separates the read path to the ROMs from the write fall-through to bank 0. Overlay RAM writes are applied with protect set and with protect cleared, so a missing guard or a leak into system RAM shows up. Bank limits are swept with two, one and four installed banks so that off-by-one top checks are caught. Port writes are aimed at neighbouring addresses and at unused bits, and the decode is sampled just before and just after the capturing edge. This exposes a wrong port match, a wrong bit, or a control path that is not registered.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  parameter int ADDR_W  = 16;
  parameter int BANK_N  = 4;
  parameter int BANK_W  = $clog2(BANK_N + 1);
  parameter int BSEL_W  = $clog2(BANK_N);
  parameter logic [7:0] PORT_MAP = 8'hF2;
  parameter logic [7:0] PORT_PROT = 8'h7F;
  parameter int MAP_BIT  = 5;
  parameter int PROT_BIT = 7;
  parameter logic [ADDR_W-1:0] OVL_END   = 16'h2000;
  parameter logic [ADDR_W-1:0] ROM1_BASE = 16'h1000;
  parameter logic [ADDR_W-1:0] ORAM_LO   = 16'h1400;
  parameter logic [ADDR_W-1:0] ORAM_HI   = 16'h17FF;
endpackage

// File: rtl/ovl_ctrl_regs.sv
module ovl_ctrl_regs
  import ovl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       io_wr_i,
  input  logic [7:0] io_addr_i,
  input  logic [7:0] io_data_i,
  output logic       ovl_en_o,
  output logic       oram_wr_ok_o
);
  logic [7:0] map_q, prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q  <= '0;
      prot_q <= '0;
    end else if (io_wr_i) begin
      if (io_addr_i == PORT_MAP)  map_q  <= io_data_i;
      if (io_addr_i == PORT_PROT) prot_q <= io_data_i;
    end
  end

  assign ovl_en_o     = ~map_q[MAP_BIT];
  assign oram_wr_ok_o = prot_q[PROT_BIT];

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_i |=> $stable(map_q) && $stable(prot_q)); // R8
  AST_MAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == PORT_MAP) |=> map_q == $past(io_data_i)); // R2
  AST_PROT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == PORT_PROT) |=> prot_q == $past(io_data_i)); // R6
endmodule

// File: rtl/ovl_region_decode.sv
module ovl_region_decode
  import ovl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ovl_en_i,
  output logic              hit_o,
  output logic              rom0_o,
  output logic              rom1_o,
  output logic              oram_o
);
  logic in_low, in_oram;

  assign in_low  = addr_i < OVL_END;
  assign in_oram = (addr_i >= ORAM_LO) && (addr_i <= ORAM_HI);

  assign hit_o  = ovl_en_i && in_low;
  // overlay RAM window wins over ROM 1
  assign oram_o = hit_o && in_oram;
  assign rom0_o = hit_o && (addr_i < ROM1_BASE);
  assign rom1_o = hit_o && (addr_i >= ROM1_BASE) && !in_oram;
endmodule

// File: rtl/sram_bank_decode.sv
module sram_bank_decode
  import ovl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic [BANK_W-1:0] banks_i,
  output logic [BANK_N-1:0] sel_o
);
  localparam int TOP = ADDR_W - 1;
  localparam int LSB = ADDR_W - BSEL_W;

  logic [BSEL_W-1:0] idx;
  assign idx = addr_i[TOP:LSB];

  for (genvar k = 0; k < BANK_N; k++) begin : g_bank
    assign sel_o[k] = en_i && (idx == BSEL_W'(k)) && (BANK_W'(k) < banks_i);
  end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import ovl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              io_wr_i,
  input  logic [7:0]        io_addr_i,
  input  logic [7:0]        io_data_i,
  input  logic [BANK_W-1:0] banks_i,
  output logic              rom0_cs_o,
  output logic              rom1_cs_o,
  output logic              oram_cs_o,
  output logic [BANK_N-1:0] sram_cs_o,
  output logic              wr_en_o
);
  logic ovl_en, oram_wr_ok;
  logic hit, rom0, rom1, oram;
  logic access, sram_en;

  ovl_ctrl_regs u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .io_wr_i      (io_wr_i),
    .io_addr_i    (io_addr_i),
    .io_data_i    (io_data_i),
    .ovl_en_o     (ovl_en),
    .oram_wr_ok_o (oram_wr_ok)
  );

  ovl_region_decode u_region (
    .addr_i   (addr_i),
    .ovl_en_i (ovl_en),
    .hit_o    (hit),
    .rom0_o   (rom0),
    .rom1_o   (rom1),
    .oram_o   (oram)
  );

  assign access = rd_i || wr_i;

  always_comb begin
    rom0_cs_o = 1'b0;
    rom1_cs_o = 1'b0;
    oram_cs_o = 1'b0;
    sram_en   = 1'b0;
    if (hit) begin
      if (oram)        oram_cs_o = access && (!wr_i || oram_wr_ok);
      else if (wr_i)   sram_en   = 1'b1;  // ROM write falls through
      else begin
        rom0_cs_o = rd_i && rom0;
        rom1_cs_o = rd_i && rom1;
      end
    end else begin
      sram_en = access;
    end
  end

  sram_bank_decode u_banks (
    .addr_i  (addr_i),
    .en_i    (sram_en),
    .banks_i (banks_i),
    .sel_o   (sram_cs_o)
  );

  assign wr_en_o = wr_i && (rom0_cs_o || rom1_cs_o || oram_cs_o || (|sram_cs_o));

  AST_ONE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom0_cs_o, rom1_cs_o, oram_cs_o, sram_cs_o})); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |-> !(rom0_cs_o || rom1_cs_o || oram_cs_o || (|sram_cs_o))); // R9
  AST_OVL_READ_NO_SRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_en && rd_i && !wr_i && addr_i < OVL_END) |-> sram_cs_o == '0); // R3
  AST_ROM_WRITE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_en && wr_i && addr_i < OVL_END && !oram) |-> sram_cs_o[0] && wr_en_o); // R4
  AST_PROT_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && oram && wr_i && !oram_wr_ok) |-> !oram_cs_o && !wr_en_o); // R6
  AST_ORAM_NO_SRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && oram) |-> sram_cs_o == '0); // R6
  AST_BANK_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BANK_W'(addr_i[ADDR_W-1:ADDR_W-BSEL_W]) >= banks_i) |-> sram_cs_o == '0); // R7
endmodule

// File: tb/sim_boot_overlay_decoder.sv
module sim_boot_overlay_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_addr = '0, io_data = '0;
  logic [2:0]  banks = 3'd4;
  logic        rom0_cs, rom1_cs, oram_cs, wr_en;
  logic [3:0]  sram_cs;
  int          n_chk = 0, n_bad = 0;

  // sel vector: {rom0, rom1, oram, sram[3:0], wr_en}
  localparam logic [7:0] NONE = 8'h00, ROM0 = 8'h80, ROM1 = 8'h40, ORAM = 8'h20;
  localparam logic [7:0] S0 = 8'h02, S1 = 8'h04, S2 = 8'h08, S3 = 8'h10, WE = 8'h01;

  always #2.5 clk = ~clk;

  boot_overlay_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .io_wr_i(io_wr), .io_addr_i(io_addr), .io_data_i(io_data), .banks_i(banks),
    .rom0_cs_o(rom0_cs), .rom1_cs_o(rom1_cs), .oram_cs_o(oram_cs),
    .sram_cs_o(sram_cs), .wr_en_o(wr_en)
  );

  function automatic logic [7:0] sel();
    return {rom0_cs, rom1_cs, oram_cs, sram_cs, wr_en};
  endfunction

  task automatic chk(string req, logic [7:0] exp);
    n_chk++;
    if (sel() !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h rd=%b wr=%b got=%h exp=%h", req, addr, rd, wr, sel(), exp);
    end
  endtask

  task automatic acc(logic [15:0] a, logic r, logic w, string req, logic [7:0] exp);
    @(negedge clk);
    addr = a; rd = r; wr = w;
    #1 chk(req, exp);
  endtask

  task automatic portw(logic [7:0] pa, logic [7:0] pd);
    @(negedge clk);
    rd = 0; wr = 0;
    io_wr = 1; io_addr = pa; io_data = pd;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic t_reset;
    acc(16'h0000, 1, 0, "R1", ROM0);
    acc(16'h1400, 0, 1, "R1", NONE);
    acc(16'h0FFF, 1, 0, "R3", ROM0);
    acc(16'h1000, 1, 0, "R3", ROM1);
    acc(16'h13FF, 1, 0, "R3", ROM1);
    acc(16'h1800, 1, 0, "R3", ROM1);
    acc(16'h1FFF, 1, 0, "R3", ROM1);
    acc(16'h1400, 1, 0, "R5", ORAM);
    acc(16'h17FF, 1, 0, "R5", ORAM);
    acc(16'h2000, 1, 0, "R7", S0);
  endtask

  task automatic t_rom_write;
    acc(16'h0000, 0, 1, "R4", S0 | WE);
    acc(16'h13FF, 0, 1, "R4", S0 | WE);
    acc(16'h1FFF, 0, 1, "R4", S0 | WE);
    acc(16'h0800, 1, 1, "R9", S0 | WE);
  endtask

  task automatic t_protect;
    acc(16'h17FF, 0, 1, "R6", NONE);
    portw(8'h7F, 8'h80);
    acc(16'h1400, 0, 1, "R6", ORAM | WE);
    acc(16'h17FF, 0, 1, "R6", ORAM | WE);
    portw(8'h7F, 8'h00);
    acc(16'h1400, 0, 1, "R6", NONE);
  endtask

  task automatic t_overlay_off;
    portw(8'hF2, 8'h20);
    acc(16'h0000, 1, 0, "R2", S0);
    acc(16'h1400, 1, 0, "R2", S0);
    acc(16'h1400, 0, 1, "R2", S0 | WE);
    acc(16'h1FFF, 1, 0, "R2", S0);
    portw(8'hF2, 8'h00);
    acc(16'h0000, 1, 0, "R2", ROM0);
  endtask

  task automatic t_banks;
    banks = 3'd2;
    acc(16'h4000, 1, 0, "R7", S1);
    acc(16'h7FFF, 0, 1, "R7", S1 | WE);
    acc(16'h8000, 1, 0, "R7", NONE);
    acc(16'hC000, 0, 1, "R7", NONE);
    banks = 3'd1;
    acc(16'h3FFF, 1, 0, "R7", S0);
    acc(16'h4000, 1, 0, "R7", NONE);
    acc(16'h0000, 0, 1, "R4", S0 | WE);
    banks = 3'd4;
    acc(16'hBFFF, 1, 0, "R7", S2);
    acc(16'hC000, 1, 0, "R7", S3);
    acc(16'hFFFF, 0, 1, "R7", S3 | WE);
  endtask

  task automatic t_idle;
    acc(16'h0000, 0, 0, "R9", NONE);
    acc(16'h1400, 0, 0, "R9", NONE);
    acc(16'h8000, 0, 0, "R9", NONE);
  endtask

  task automatic t_port_isolation;
    portw(8'hF3, 8'h20);
    acc(16'h0000, 1, 0, "R8", ROM0);
    portw(8'hF2, 8'hDF);
    acc(16'h0000, 1, 0, "R8", ROM0);
    portw(8'h7F, 8'h7F);
    acc(16'h1400, 0, 1, "R8", NONE);
    portw(8'h7E, 8'h80);
    acc(16'h1400, 0, 1, "R8", NONE);
    portw(8'hF2, 8'h20);
    portw(8'h7F, 8'h80);
    acc(16'h0000, 1, 0, "R8", S0);
    portw(8'hF2, 8'h00);
    acc(16'h1400, 0, 1, "R8", ORAM | WE);
    portw(8'h7F, 8'h00);
  endtask

  task automatic t_timing;
    @(negedge clk);
    addr = 16'h0000; rd = 1; wr = 0;
    io_wr = 1; io_addr = 8'hF2; io_data = 8'h20;
    #1 chk("R10", ROM0);
    @(posedge clk);
    #1 chk("R10", S0);
    @(negedge clk);
    io_wr = 1; io_data = 8'h00;
    #1 chk("R10", S0);
    @(posedge clk);
    #1 chk("R10", ROM0);
    @(negedge clk);
    io_wr = 0; rd = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1 chk("R9", NONE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rom_write();
    t_protect();
    t_overlay_off();
    t_banks();
    t_idle();
    t_port_isolation();
    t_timing();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule